// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a four-bank synchronous DRAM, exactly as the memory samples them on each rising clock edge. It turns the clock-enable, chip-select, row-strobe, column-strobe and write-enable levels into one discrete command event per cycle. The auto-precharge/all-banks address bit and the bank-select bits qualify that event. Each command appears on a one-hot output together with the addressed bank and the two address-bit qualifiers.

Alongside the decoder, the block keeps a tracker for each bank. The tracker records whether the bank has an open row and which row that is. It also runs a countdown after a read or write that asked for auto-precharge, and closes the bank by itself when that countdown ends. The block compares each command with the tracker state it finds and pulses a violation flag when the command breaks the ordering rules. The block can therefore sit beside a memory controller as a passive protocol checker.

Every output is registered. The result for the command sampled at one rising edge is visible for the whole following cycle.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While rst_n is low at a rising edge, the block takes its reset state: cmd_oh shows only the no-command bit (bit 0), bank_open and bank_row are all zero, and cmd_ap, cmd_all and violation are low. The previous-cycle clock enable is taken as high.
- R2: cmd_oh always has exactly one bit set. When the previous clock enable was high and cs_n is high, the result is the no-command code (bit 0). The pins {ras_n,cas_n,we_n}=111 with cs_n low also give bit 0.
- R3: With cs_n low and the previous clock enable high, {ras_n,cas_n,we_n} decode as follows: 000 mode-register set (bit 2), 011 activate (bit 5), 101 read (bit 6), 100 write (bit 7), 010 precharge (bit 8) and 110 burst stop (bit 9). cmd_bank repeats ba (banks 0..3). cmd_ap is addr[10] on a read or write. cmd_all is addr[10] on a precharge. Both are 0 for every other command.
- R4: The pins {ras_n,cas_n,we_n}=001 with cs_n low decode as auto refresh (bit 3) when cke is still high at that edge. They decode as self-refresh entry (bit 4) when cke is low.
- R5: When cke was low at the previous edge, the cycle decodes as clock-held (bit 1) whatever the other pins show. Bank state, auto-precharge countdowns and the violation flag stay unchanged during such a cycle.
- R6: An activate to a closed bank opens it, and bank_row then holds the row from addr. The row is kept after the bank closes. An activate to an open bank raises violation and changes neither the open flag nor the row.
- R7: A precharge with addr[10] low closes only the bank on ba. A precharge with addr[10] high closes all four banks. Either form cancels any auto-precharge countdown on the banks it closes.
- R8: A read or write to a bank that is closed raises violation and changes no bank state.
- R9: A mode-register set, auto refresh or self-refresh entry while any bank is open raises violation.
- R10: A legal read or write with addr[10] high leaves its bank open for BURST_LEN further non-held cycles and closes it at the BURST_LEN-th. A read or write to that bank within those edges raises violation.
- R11: Outputs for the command sampled at rising edge k appear right after edge k and hold until edge k+1. The violation check uses the bank state from before edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level |
| cs_n | input | 1 | Chip-select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Multiplexed address; bit AP_BIT is the auto-precharge/all-banks flag |
| cmd_oh | output | 10 | One-hot decoded command |
| cmd_bank | output | BANK_W | Bank addressed by the command |
| cmd_ap | output | 1 | Auto-precharge requested on a read or write |
| cmd_all | output | 1 | Precharge applies to all banks |
| bank_open | output | 2**BANK_W | Open flag, one bit per bank |
| bank_row | output | 2**BANK_W*ADDR_W | Last activated row per bank, bank 0 in the low bits |
| violation | output | 1 | Ordering violation for the command just decoded |

## Verification
Several properties are checked on every cycle by assertions in the RTL. The one-hot code has exactly one bit set. A low clock enable turns the next cycle into a held cycle that keeps the bank state. A legal activate captures its row. A bank is never counting down toward auto-precharge while it is closed. Precharge-all empties the bank map. Reads, writes, mode sets and refreshes that meet a closed or open bank are flagged. The exact decode of each pin pattern, the close timing of the auto-precharge window and the freezing of that window during held cycles are shown only by the bench's reference model. That model follows directed sequences and a long stretch of random pin activity.

// File: rtl/sdcm_pkg.sv
// Shared definitions for the SDRAM command decoder and bank tracker.
// Assumes: one command code per cycle, carried as a one-hot vector.
package sdcm_pkg;
    localparam int CMD_N = 10;

    // Bit positions inside the one-hot command vector.
    typedef enum int unsigned {
        C_NOP  = 0,
        C_HOLD = 1,
        C_MRS  = 2,
        C_AREF = 3,
        C_SREF = 4,
        C_ACT  = 5,
        C_RD   = 6,
        C_WR   = 7,
        C_PRE  = 8,
        C_BST  = 9
    } cmd_idx_e;
endpackage

// File: rtl/sdcm_decode.sv
// Pin-level command decoder.
// Turns the sampled control levels into a one-hot command for this edge.
// It also keeps the clock-enable level of the previous edge, which decides
// whether the current edge carries a command at all.
// Assumes: the inputs are stable around the rising edge of clk.
module sdcm_decode
    import sdcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    output logic [CMD_N-1:0] cmd_oh,
    output logic             hold
);
    logic cke_prev_q;

    // Remember the clock-enable level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev_q <= 1'b1;
        else        cke_prev_q <= cke;
    end

    assign hold = !cke_prev_q;

    // Map the strobe pattern onto a single command bit.
    always_comb begin
        cmd_oh = '0;
        if (!cke_prev_q) begin
            cmd_oh[C_HOLD] = 1'b1;
        end else if (cs_n) begin
            cmd_oh[C_NOP] = 1'b1;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd_oh[C_MRS] = 1'b1;
                3'b001:  begin
                    if (cke) cmd_oh[C_AREF] = 1'b1;
                    else     cmd_oh[C_SREF] = 1'b1;
                end
                3'b011:  cmd_oh[C_ACT] = 1'b1;
                3'b101:  cmd_oh[C_RD]  = 1'b1;
                3'b100:  cmd_oh[C_WR]  = 1'b1;
                3'b010:  cmd_oh[C_PRE] = 1'b1;
                3'b110:  cmd_oh[C_BST] = 1'b1;
                default: cmd_oh[C_NOP] = 1'b1;
            endcase
        end
    end

    AST_HOLD_AFTER_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> cmd_oh[C_HOLD]); // R5
endmodule

// File: rtl/sdcm_bank_slot.sv
// State of one bank: the open flag, the open row and the auto-precharge
// countdown.
// Assumes: the hit inputs are already qualified by bank select, and
// act_hit / rwap_hit only take effect when the bank state makes them legal.
module sdcm_bank_slot #(
    parameter int ADDR_W    = 13,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              pre_hit,
    input  logic              act_hit,
    input  logic              rwap_hit,
    input  logic [ADDR_W-1:0] row_in,
    output logic              open_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] row_o
);
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    logic              open_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] row_q;

    // Next-state for open flag, row and countdown; a held cycle keeps all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
            row_q  <= '0;
        end else if (!hold) begin
            if (pre_hit) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else if (act_hit && !open_q) begin
                open_q <= 1'b1;
                row_q  <= row_in;
            end else if (rwap_hit && open_q && cnt_q == '0) begin
                cnt_q <= CNT_W'(BURST_LEN);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) open_q <= 1'b0;
            end
        end
    end

    assign open_o = open_q;
    assign busy_o = (cnt_q != '0);
    assign row_o  = row_q;

    AST_HOLD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(open_q) && $stable(cnt_q) && $stable(row_q)); // R5
    AST_ACT_LATCHES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && act_hit && !pre_hit && !open_q) |=> open_q && row_q == $past(row_in)); // R6
    AST_BUSY_IMPLIES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> open_o); // R10
endmodule

// File: rtl/sdcm_rule_check.sv
// Ordering rules for the command decoded this cycle.
// Checks the command against the bank state from before the edge.
// Assumes: cmd_oh is one-hot; a held cycle never flags.
module sdcm_rule_check
    import sdcm_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic [CMD_N-1:0]       cmd_oh,
    input  logic [BANK_W-1:0]      bank,
    input  logic [(1<<BANK_W)-1:0] open_vec,
    input  logic [(1<<BANK_W)-1:0] busy_vec,
    output logic                   viol
);
    logic rw_bad, act_bad, global_bad;

    // Evaluate each illegal-ordering case and merge them.
    always_comb begin
        rw_bad     = (cmd_oh[C_RD] || cmd_oh[C_WR]) && (!open_vec[bank] || busy_vec[bank]);
        act_bad    = cmd_oh[C_ACT] && open_vec[bank];
        global_bad = (cmd_oh[C_MRS] || cmd_oh[C_AREF] || cmd_oh[C_SREF]) && (|open_vec);
        viol       = rw_bad || act_bad || global_bad;
    end
endmodule

// File: rtl/sdram_cmd_tracker.sv
// SDRAM command decoder and four-bank tracker, top level.
// Decodes the sampled pins, updates per-bank state and registers the
// command, its qualifiers and an ordering-violation pulse.
// Assumes: bit AP_BIT of addr is the auto-precharge / all-banks flag.
module sdram_cmd_tracker
    import sdcm_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BANK_W    = 2,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cke,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [BANK_W-1:0]             ba,
    input  logic [ADDR_W-1:0]             addr,
    output logic [CMD_N-1:0]              cmd_oh,
    output logic [BANK_W-1:0]             cmd_bank,
    output logic                          cmd_ap,
    output logic                          cmd_all,
    output logic [(1<<BANK_W)-1:0]        bank_open,
    output logic [(1<<BANK_W)*ADDR_W-1:0] bank_row,
    output logic                          violation
);
    localparam int NBANK = 1 << BANK_W;

    logic [CMD_N-1:0] dec_oh;
    logic             hold;
    logic             ap_bit;
    logic             is_rw;
    logic [NBANK-1:0] open_vec, busy_vec;
    logic             viol_c;

    assign ap_bit = addr[AP_BIT];
    assign is_rw  = dec_oh[C_RD] || dec_oh[C_WR];

    sdcm_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke    (cke),
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cmd_oh (dec_oh),
        .hold   (hold)
    );

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic sel;
        assign sel = (ba == BANK_W'(i));

        sdcm_bank_slot #(
            .ADDR_W    (ADDR_W),
            .BURST_LEN (BURST_LEN)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (hold),
            .pre_hit  (dec_oh[C_PRE] && (ap_bit || sel)),
            .act_hit  (dec_oh[C_ACT] && sel),
            .rwap_hit (is_rw && ap_bit && sel),
            .row_in   (addr),
            .open_o   (open_vec[i]),
            .busy_o   (busy_vec[i]),
            .row_o    (bank_row[i*ADDR_W +: ADDR_W])
        );
    end

    sdcm_rule_check #(
        .BANK_W (BANK_W)
    ) u_rules (
        .cmd_oh   (dec_oh),
        .bank     (ba),
        .open_vec (open_vec),
        .busy_vec (busy_vec),
        .viol     (viol_c)
    );

    // Register the decoded command and its qualifiers for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_oh    <= CMD_N'(1) << C_NOP;
            cmd_bank  <= '0;
            cmd_ap    <= 1'b0;
            cmd_all   <= 1'b0;
            violation <= 1'b0;
        end else begin
            cmd_oh    <= dec_oh;
            cmd_bank  <= ba;
            cmd_ap    <= is_rw && ap_bit;
            cmd_all   <= dec_oh[C_PRE] && ap_bit;
            violation <= viol_c;
        end
    end

    assign bank_open = open_vec;

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_oh) == 1); // R2
    AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_oh[C_PRE] && ap_bit) |=> bank_open == '0); // R7
    AST_RW_CLOSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && !open_vec[ba]) |=> violation); // R8
    AST_GLOBAL_OPEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_oh[C_MRS] || dec_oh[C_AREF] || dec_oh[C_SREF]) && (|open_vec)) |=> violation); // R9
endmodule

// File: tb/tb_sdram_cmd_tracker.sv
// Bench: behavioural reference model, compared on every falling edge.
module tb_sdram_cmd_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 13;
    localparam int BL  = 4;
    localparam int MAX_CYCLES = 20000;

    // Pin codes {cs_n,ras_n,cas_n,we_n}
    localparam logic [3:0] P_NOP = 4'b0111, P_DES = 4'b1000, P_MRS = 4'b0000,
                           P_REF = 4'b0001, P_ACT = 4'b0011, P_RD  = 4'b0101,
                           P_WR  = 4'b0100, P_PRE = 4'b0010, P_BST = 4'b0110;

    logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
    logic [1:0]    ba = 0;
    logic [AW-1:0] addr = 0;
    logic [9:0]    cmd_oh;
    logic [1:0]    cmd_bank;
    logic          cmd_ap, cmd_all, violation;
    logic [3:0]    bank_open;
    logic [4*AW-1:0] bank_row;

    sdram_cmd_tracker #(.ADDR_W(AW), .BANK_W(2), .AP_BIT(10), .BURST_LEN(BL)) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_oh(cmd_oh),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_all(cmd_all),
        .bank_open(bank_open), .bank_row(bank_row), .violation(violation));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0, model_ok = 0;
    string tag_in = "R1", tag_exp = "R1";

    // Reference model state
    bit m_open[4];
    int m_cnt[4];
    int m_row[4];
    bit m_ckep = 1;
    int e_idx = 0;
    int e_bank = 0;
    bit e_ap = 0, e_all = 0, e_viol = 0;

    always @(posedge clk) begin
        tag_exp = tag_in;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_cnt[i] = 0; m_row[i] = 0; end
            m_ckep = 1; e_idx = 0; e_bank = 0; e_ap = 0; e_all = 0; e_viol = 0;
        end else begin
            int b;
            bit a10;
            b = int'(ba); a10 = addr[10];
            e_bank = b; e_ap = 0; e_all = 0; e_viol = 0;
            if (!m_ckep) e_idx = 1;
            else if (cs_n) e_idx = 0;
            else begin
                case ({ras_n, cas_n, we_n})
                    3'b000: e_idx = 2;
                    3'b001: e_idx = cke ? 3 : 4;
                    3'b011: e_idx = 5;
                    3'b101: e_idx = 6;
                    3'b100: e_idx = 7;
                    3'b010: e_idx = 8;
                    3'b110: e_idx = 9;
                    default: e_idx = 0;
                endcase
            end
            if (e_idx != 1) begin
                bit anyopen;
                bit pre_open[4];
                int pre_cnt[4];
                anyopen = 0;
                for (int i = 0; i < 4; i++) begin
                    pre_open[i] = m_open[i]; pre_cnt[i] = m_cnt[i];
                    if (m_open[i]) anyopen = 1;
                end
                if (e_idx == 6 || e_idx == 7) begin
                    e_ap = a10;
                    e_viol = !pre_open[b] || pre_cnt[b] != 0;
                end
                if (e_idx == 5) e_viol = pre_open[b];
                if (e_idx >= 2 && e_idx <= 4) e_viol = anyopen;
                if (e_idx == 8) e_all = a10;
                // countdown
                for (int i = 0; i < 4; i++)
                    if (m_cnt[i] > 0) begin
                        m_cnt[i]--;
                        if (m_cnt[i] == 0) m_open[i] = 0;
                    end
                // command effects
                if (e_idx == 8) begin
                    for (int i = 0; i < 4; i++)
                        if (a10 || i == b) begin m_open[i] = 0; m_cnt[i] = 0; end
                end else if (e_idx == 5 && !pre_open[b]) begin
                    m_open[b] = 1; m_row[b] = int'(addr);
                end else if ((e_idx == 6 || e_idx == 7) && a10 && pre_open[b] && pre_cnt[b] == 0) begin
                    m_cnt[b] = BL;
                end
            end
            m_ckep = cke;
        end
        model_ok = 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_ok && !done) begin
            logic [9:0]    x_cmd;
            logic [3:0]    x_open;
            logic [4*AW-1:0] x_row;
            x_cmd = 10'(1) << e_idx;
            for (int i = 0; i < 4; i++) begin
                x_open[i] = m_open[i];
                x_row[i*AW +: AW] = AW'(m_row[i]);
            end
            check(cmd_oh === x_cmd && cmd_bank === 2'(e_bank) && cmd_ap === e_ap && cmd_all === e_all,
                  tag_exp, "cmd/bank/ap/all", {cmd_oh, cmd_bank, cmd_ap, cmd_all},
                  {x_cmd, 2'(e_bank), e_ap, e_all});
            check(bank_open === x_open && bank_row === x_row, tag_exp, "bank state",
                  {bank_open, bank_row[AW*4-1 -: 32]}, {x_open, x_row[AW*4-1 -: 32]});
            check(violation === e_viol, tag_exp, "violation", 64'(violation), 64'(e_viol));
        end
    end

    task automatic put(input string t, input logic k, input logic [3:0] p,
                       input logic [1:0] b, input logic [AW-1:0] a);
        @(posedge clk); #1;
        tag_in = t; cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; addr = a;
    endtask

    localparam logic [AW-1:0] A10 = AW'(1) << 10;

    initial begin
        // R1: reset state
        rst_n = 0;
        repeat (3) put("R1", 1, P_NOP, 0, 0);
        @(posedge clk); #1; rst_n = 1;
        put("R2", 1, P_DES, 2'd3, AW'(13'h1fff));      // R2 deselect
        put("R2", 1, P_NOP, 0, 0);
        put("R6", 1, P_ACT, 2'd1, AW'(13'h123));       // R6 open bank1
        put("R6", 1, P_ACT, 2'd1, AW'(13'h456));       // R6 open again: flag
        put("R3", 1, P_RD,  2'd1, AW'(0));             // R3 read no ap
        put("R3", 1, P_WR,  2'd1, AW'(5));             // R3 write no ap
        put("R8", 1, P_WR,  2'd2, AW'(0));             // R8 closed bank
        put("R8", 1, P_RD,  2'd0, A10);                // R8 closed with ap
        put("R9", 1, P_MRS, 2'd0, AW'(0));             // R9
        put("R9", 1, P_REF, 2'd0, AW'(0));             // R9
        put("R3", 1, P_BST, 2'd2, AW'(0));             // R3 burst stop
        put("R10", 1, P_RD, 2'd1, A10);                // R10 read with ap
        put("R10", 1, P_RD, 2'd1, AW'(0));             // R10 in window
        put("R10", 1, P_WR, 2'd1, A10);
        put("R10", 1, P_NOP, 0, 0);
        put("R10", 1, P_NOP, 0, 0);                    // closes here
        put("R10", 1, P_RD, 2'd1, AW'(0));             // closed now
        put("R11", 1, P_ACT, 2'd0, AW'(13'h0aa));
        put("R11", 1, P_ACT, 2'd3, AW'(13'h1f0));
        put("R7", 1, P_PRE, 2'd0, AW'(0));             // R7 single
        put("R7", 1, P_ACT, 2'd2, AW'(13'h077));
        put("R7", 1, P_PRE, 2'd1, A10);                // R7 all banks
        put("R4", 1, P_REF, 2'd0, AW'(0));             // R4 auto refresh
        put("R4", 0, P_REF, 2'd0, AW'(0));             // R4 self refresh entry
        put("R5", 0, P_ACT, 2'd2, AW'(13'h0ff));       // R5 held
        put("R5", 1, P_ACT, 2'd2, AW'(13'h0ff));       // still held
        put("R5", 1, P_ACT, 2'd2, AW'(13'h0ee));       // live again
        put("R5", 1, P_WR,  2'd2, A10);                // window starts
        put("R5", 0, P_NOP, 0, 0);
        put("R5", 0, P_RD,  2'd2, AW'(0));             // held: no flag
        put("R5", 1, P_NOP, 0, 0);                     // held
        put("R5", 1, P_RD,  2'd2, AW'(0));             // window still busy
        repeat (4) put("R5", 1, P_NOP, 0, 0);
        put("R3", 1, P_MRS, 2'd3, AW'(13'h033));       // R3 legal mode set
        put("R3", 1, P_PRE, 2'd2, AW'(0));
        // random phase
        for (int n = 0; n < 600; n++) begin
            logic [3:0] p;
            p = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) != 0) p[3] = 0;
            put("R11", ($urandom_range(0, 9) != 0), p, 2'($urandom_range(0, 3)), AW'($urandom));
        end
        put("R11", 1, P_NOP, 0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule